// File: doc/BRIEF.md
# Prime-Modulus Residue Multiplier by Discrete Logarithm

This block multiplies two residues modulo a prime `P` without a multiplier array. It moves each nonzero operand into the exponent domain with a lookup table, which maps a value to its power of a primitive root `ROOT`. It adds the two exponents modulo `P - 1` in a two-stage carry-select adder. A second lookup table then maps the exponent sum back to a residue, and that residue is the product. Zero has no exponent, so a zero on either operand is flagged at the input. The flag travels down the pipeline beside the data and forces the result to zero.

Both tables are computed at elaboration by constant functions in the package. Changing `P` and `ROOT` therefore gives a multiplier for any supported prime without a memory file. The operand width follows from `P`. The block is fully pipelined and accepts one operand pair per cycle. Its total latency is the parameter `LAT`. Four stages carry the arithmetic and `LAT - 4` padding stages follow them, so the block can match neighbours that use a different table implementation.

Top module: `gf_index_mul`

## Requirements
- R1: When `in_valid` is high and both operands are below `P`, the `product` delivered for that pair equals (op_a * op_b) mod P.
- R2: `out_valid` equals `in_valid` delayed by exactly `LAT` clock cycles, and the product appears in the same cycle as its `out_valid`.
- R3: Exponent sums that reach or exceed `P - 1` wrap modulo `P - 1`, so a pair whose product is 1 (an operand and its inverse) yields 1.
- R4: If either operand is 0, the delivered product is 0.
- R5: A synchronous active-high `rst` clears all pending results: `out_valid` is low during reset and stays low for the `LAT` cycles that follow an idle input.
- R6: Results stream back to back at one per cycle, and gaps in `in_valid` are kept in their positions at the output.
- R7: The same RTL, with `P = 251` and `ROOT = 6`, gives an 8-bit multiplier that is correct for every operand pair, so the widths derived from `P` hold at the top of the supported range.
- R8: For two nonzero operands, the delivered product is nonzero and below `P`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present this cycle |
| op_a | input | W = $clog2(P) | First residue, 0 to P-1 |
| op_b | input | W | Second residue, 0 to P-1 |
| out_valid | output | 1 | Product present this cycle |
| product | output | W | (op_a * op_b) mod P |

## Verification
The multiplier is swept over every operand pair at `P = 31`, and a second instance sweeps every pair at `P = 251`. The two sweeps separate wrong table contents and width truncation from faults in the adder. In the sweeps, pairs that contain zero isolate the bypass flag. Pairs whose product is 1 land exactly on the `P - 1` wrap of the exponent sum, which separates a carry-select fault from an error in a lookup. A lone valid pulse measures the latency. An irregular valid pattern with gaps, and a reset in the middle of a stream, show whether the valid flag is aligned and flushed separately from the data.

// File: rtl/gf_mul_pkg.sv
package gf_mul_pkg;

    typedef struct packed {
        logic valid;
        logic zero;
    } gf_ctl_t;

    // Exponent of value v for root r modulo prime p; 0 for v outside 1..p-1.
    function automatic int log_mod(int p, int r, int v);
        int acc;
        acc = 1;
        for (int i = 0; i < p - 1; i++) begin
            if (acc == v) return i;
            acc = (acc * r) % p;
        end
        return 0;
    endfunction

    // r raised to e modulo p, for e in 0..p-2; 0 for e outside that range.
    function automatic int pow_mod(int p, int r, int e);
        int acc;
        if (e >= p - 1) return 0;
        acc = 1;
        for (int i = 0; i < e; i++) acc = (acc * r) % p;
        return acc;
    endfunction

endpackage

// File: rtl/gf_lut.sv
module gf_lut #(
    parameter int P       = 31,
    parameter int ROOT    = 3,
    parameter int W       = 5,
    parameter bit INVERSE = 1'b0
) (
    input  logic         clk,
    input  logic [W-1:0] addr,
    output logic [W-1:0] data
);
    localparam int DEPTH = 1 << W;

    logic [W-1:0] table_q [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_entry
        localparam int VAL = INVERSE ? gf_mul_pkg::pow_mod(P, ROOT, a)
                                     : gf_mul_pkg::log_mod(P, ROOT, a);
        assign table_q[a] = VAL[W-1:0];
    end

    always_ff @(posedge clk) begin
        data <= table_q[addr];
    end
endmodule

// File: rtl/gf_mod_adder.sv
module gf_mod_adder #(
    parameter int W = 5,
    parameter int M = 30
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [W-1:0]        a,
    input  logic [W-1:0]        b,
    input  gf_mul_pkg::gf_ctl_t ctl_in,
    output logic [W-1:0]        sum,
    output gf_mul_pkg::gf_ctl_t ctl_out
);
    import gf_mul_pkg::*;

    localparam int      OFFS_I = (1 << W) - M;
    localparam [W-1:0]  OFFS   = OFFS_I[W-1:0];

    logic [W:0]   raw_q;
    gf_ctl_t      ctl_q;
    logic [W:0]   adj;

    always_ff @(posedge clk) begin
        raw_q <= {1'b0, a} + {1'b0, b};
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_in;
    end

    assign adj = {1'b0, raw_q[W-1:0]} + {1'b0, OFFS};

    always_ff @(posedge clk) begin
        sum <= (raw_q[W] | adj[W]) ? adj[W-1:0] : raw_q[W-1:0];
        if (rst) ctl_out <= '0;
        else     ctl_out <= ctl_q;
    end
endmodule

// File: rtl/gf_delay_line.sv
module gf_delay_line #(
    parameter int DEPTH = 3,
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    if (DEPTH == 0) begin : g_wire
        assign dout = din;
    end else begin : g_regs
        logic [WIDTH-1:0] stage_q [DEPTH];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
            end else begin
                stage_q[0] <= din;
                for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
            end
        end
        assign dout = stage_q[DEPTH-1];
    end
endmodule

// File: rtl/gf_index_mul.sv
module gf_index_mul #(
    parameter int P    = 31,
    parameter int ROOT = 3,
    parameter int LAT  = 7,
    localparam int W   = $clog2(P)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         out_valid,
    output logic [W-1:0] product
);
    import gf_mul_pkg::*;

    localparam int CORE = 4;
    localparam int PAD  = (LAT > CORE) ? LAT - CORE : 0;

    // Stage 1: parallel index lookups, zero detection.
    logic [W-1:0] idx_a, idx_b;
    gf_ctl_t      ctl_in, ctl_idx;

    assign ctl_in.valid = in_valid;
    assign ctl_in.zero  = (op_a == '0) || (op_b == '0);

    gf_lut #(.P(P), .ROOT(ROOT), .W(W), .INVERSE(1'b0)) u_log_a (
        .clk(clk), .addr(op_a), .data(idx_a));
    gf_lut #(.P(P), .ROOT(ROOT), .W(W), .INVERSE(1'b0)) u_log_b (
        .clk(clk), .addr(op_b), .data(idx_b));

    always_ff @(posedge clk) begin
        if (rst) ctl_idx <= '0;
        else     ctl_idx <= ctl_in;
    end

    // Stages 2-3: index sum modulo P-1.
    logic [W-1:0] idx_sum;
    gf_ctl_t      ctl_sum;
    logic         sum_vld;

    gf_mod_adder #(.W(W), .M(P - 1)) u_add (
        .clk(clk), .rst(rst), .a(idx_a), .b(idx_b),
        .ctl_in(ctl_idx), .sum(idx_sum), .ctl_out(ctl_sum));

    assign sum_vld = ctl_sum.valid & ~ctl_sum.zero;

    // Stage 4: inverse lookup and zero bypass.
    logic [W-1:0] pow_val;
    gf_ctl_t      ctl_pow;
    logic [W-1:0] prod_core;

    gf_lut #(.P(P), .ROOT(ROOT), .W(W), .INVERSE(1'b1)) u_pow (
        .clk(clk), .addr(idx_sum), .data(pow_val));

    always_ff @(posedge clk) begin
        if (rst) ctl_pow <= '0;
        else     ctl_pow <= ctl_sum;
    end

    assign prod_core = ctl_pow.zero ? '0 : pow_val;

    // Padding stages to reach LAT.
    logic [W:0] tail;

    gf_delay_line #(.DEPTH(PAD), .WIDTH(W + 1)) u_pad (
        .clk(clk), .rst(rst), .din({ctl_pow.valid, prod_core}), .dout(tail));

    assign out_valid = tail[W];
    assign product   = tail[W-1:0];
endmodule

// File: rtl/gf_index_mul_chk.sv
module gf_index_mul_chk #(
    parameter int P   = 31,
    parameter int LAT = 7,
    parameter int W   = 5
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         out_valid,
    input logic [W-1:0] product,
    input logic         sum_vld,
    input logic [W-1:0] idx_sum
);
    logic [LAT-1:0] vhist, zhist;

    always_ff @(posedge clk) begin
        if (rst) begin
            vhist <= '0;
            zhist <= '0;
        end else begin
            vhist <= {vhist[LAT-2:0], in_valid};
            zhist <= {zhist[LAT-2:0], (op_a == '0) || (op_b == '0)};
        end
    end

    // R2: output valid follows input valid after LAT cycles
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid == vhist[LAT-1]);

    // R3: index sum stays inside 0..P-2
    a_r3_sum_wrap: assert property (@(posedge clk) disable iff (rst)
        sum_vld |-> (int'(idx_sum) < P - 1));

    // R4: zero operand gives zero product
    a_r4_zero_bypass: assert property (@(posedge clk) disable iff (rst)
        (vhist[LAT-1] && zhist[LAT-1]) |-> (product == '0));

    // R8: nonzero operands give a nonzero product below P
    a_r8_nonzero_range: assert property (@(posedge clk) disable iff (rst)
        (vhist[LAT-1] && !zhist[LAT-1]) |-> (product != '0 && int'(product) < P));

    // R5: the cycle after reset shows no valid output
    a_r5_flush: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid);
endmodule

bind gf_index_mul gf_index_mul_chk #(.P(P), .LAT(LAT), .W(W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .product(product),
    .sum_vld(sum_vld), .idx_sum(idx_sum));

// File: tb/gf_index_mul_test.sv
module gf_index_mul_test;
    localparam int PA = 31,  RA = 3, LA = 7, WA = 5;
    localparam int PB = 251, RB = 6, LB = 9, WB = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          a_v = 1'b0, b_v = 1'b0;
    logic [WA-1:0] a_x = '0, a_y = '0;
    logic [WB-1:0] b_x = '0, b_y = '0;
    logic          a_ov, b_ov;
    logic [WA-1:0] a_p;
    logic [WB-1:0] b_p;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    gf_index_mul #(.P(PA), .ROOT(RA), .LAT(LA)) uut (
        .clk(clk), .rst(rst), .in_valid(a_v), .op_a(a_x), .op_b(a_y),
        .out_valid(a_ov), .product(a_p));

    gf_index_mul #(.P(PB), .ROOT(RB), .LAT(LB)) uut_wide (
        .clk(clk), .rst(rst), .in_valid(b_v), .op_a(b_x), .op_b(b_y),
        .out_valid(b_ov), .product(b_p));

    // Expected-value history, one slot per cycle of latency.
    int ha_v[LA], ha_x[LA], ha_y[LA];
    int hb_v[LB], hb_x[LB], hb_y[LB];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LA; i++) begin ha_v[i] <= 0; ha_x[i] <= 0; ha_y[i] <= 0; end
            for (int i = 0; i < LB; i++) begin hb_v[i] <= 0; hb_x[i] <= 0; hb_y[i] <= 0; end
        end else begin
            ha_v[0] <= int'(a_v); ha_x[0] <= int'(a_x); ha_y[0] <= int'(a_y);
            for (int i = 1; i < LA; i++) begin
                ha_v[i] <= ha_v[i-1]; ha_x[i] <= ha_x[i-1]; ha_y[i] <= ha_y[i-1];
            end
            hb_v[0] <= int'(b_v); hb_x[0] <= int'(b_x); hb_y[0] <= int'(b_y);
            for (int i = 1; i < LB; i++) begin
                hb_v[i] <= hb_v[i-1]; hb_x[i] <= hb_x[i-1]; hb_y[i] <= hb_y[i-1];
            end
        end
    end

    task automatic compare(string base, int p, int ov, int prod, int ev, int x, int y);
        string tag;
        int    exp_p;
        n_chk++;
        if (ov != ev) begin
            n_fail++;
            $display("FAIL R2/R6 %s out_valid: actual %0d expected %0d", base, ov, ev);
        end else if (ev != 0) begin
            exp_p = (x * y) % p;
            if (x == 0 || y == 0) tag = "R4";
            else if (exp_p == 1)  tag = "R3";
            else                  tag = base;
            if (prod != exp_p) begin
                n_fail++;
                $display("FAIL %s %0d*%0d mod %0d: actual %0d expected %0d",
                         tag, x, y, p, prod, exp_p);
            end
        end
    endtask

    // Automatic scoreboard: R1 for the narrow unit, R7 for the wide one.
    always @(negedge clk) begin
        if (!rst && !done) begin
            compare("R1", PA, int'(a_ov), int'(a_p), ha_v[LA-1], ha_x[LA-1], ha_y[LA-1]);
            compare("R7", PB, int'(b_ov), int'(b_p), hb_v[LB-1], hb_x[LB-1], hb_y[LB-1]);
        end
    end

    task automatic idle(int n);
        @(negedge clk);
        a_v = 1'b0; b_v = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state;
        // R5: outputs quiet while reset is held
        rst = 1'b1;
        repeat (3) @(negedge clk);
        n_chk++;
        if (a_ov !== 1'b0 || b_ov !== 1'b0) begin
            n_fail++;
            $display("FAIL R5 reset out_valid: actual %0b/%0b expected 0/0", a_ov, b_ov);
        end
        rst = 1'b0;
    endtask

    task automatic t_latency;
        int cnt;
        // R2: lone pulse, count cycles to out_valid
        idle(LB + 2);
        a_v = 1'b1; a_x = 5'd7; a_y = 5'd9;
        @(negedge clk);
        a_v = 1'b0;
        cnt = 1;
        while (a_ov !== 1'b1 && cnt < 40) begin
            @(negedge clk);
            cnt++;
        end
        n_chk++;
        if (cnt != LA) begin
            n_fail++;
            $display("FAIL R2 latency: actual %0d expected %0d", cnt, LA);
        end
    endtask

    task automatic t_sweep_narrow;
        // R1, R3, R4: every pair for P=31
        for (int x = 0; x < PA; x++)
            for (int y = 0; y < PA; y++) begin
                a_v = 1'b1; a_x = WA'(x); a_y = WA'(y);
                @(negedge clk);
            end
        idle(LA + 2);
    endtask

    task automatic t_sweep_wide;
        // R7: every pair for P=251
        for (int x = 0; x < PB; x++)
            for (int y = 0; y < PB; y++) begin
                b_v = 1'b1; b_x = WB'(x); b_y = WB'(y);
                @(negedge clk);
            end
        idle(LB + 2);
    endtask

    task automatic t_bubbles;
        // R6: irregular valid pattern on both units
        for (int i = 0; i < 300; i++) begin
            a_v = ((i % 3) != 0) || ((i % 7) == 0);
            b_v = ((i % 5) < 2);
            a_x = WA'($urandom_range(PA - 1)); a_y = WA'($urandom_range(PA - 1));
            b_x = WB'($urandom_range(PB - 1)); b_y = WB'($urandom_range(PB - 1));
            @(negedge clk);
        end
        idle(LB + 2);
    endtask

    task automatic t_mid_reset;
        // R5: reset during a stream flushes pending results
        for (int i = 0; i < 4; i++) begin
            a_v = 1'b1; b_v = 1'b1;
            a_x = WA'(i + 2); a_y = 5'd3; b_x = WB'(i + 10); b_y = 8'd5;
            @(negedge clk);
        end
        a_v = 1'b0; b_v = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < LB; i++) begin
            @(negedge clk);
            n_chk++;
            if (a_ov !== 1'b0 || b_ov !== 1'b0) begin
                n_fail++;
                $display("FAIL R5 post-reset out_valid: actual %0b/%0b expected 0/0", a_ov, b_ov);
            end
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        t_reset_state();
        t_latency();
        t_sweep_narrow();
        t_sweep_wide();
        t_bubbles();
        t_mid_reset();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end
endmodule